// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block merges four reset requests into a single system reset: an asynchronous, active-low external pin, a watchdog overflow pulse, a supply-voltage trip from the low-voltage detector and an oscillation-stop pulse from the clock monitor. Once every request has gone away, the reset is held for a fixed number of cycles. A main-oscillator stabilization wait then follows before the CPU may run. A small register bus lets software find out which internal source caused the last reset. The same bus reaches the two configuration registers of the low-voltage detector, which this block owns.

If the watchdog overflows while the block waits for the main oscillator to stabilize, the oscillator is taken to be faulty. The block then selects the internal oscillator and enters an emergency mode. In that mode a peripheral access to an identifier outside a permitted set is flagged as illegal. The analog comparator, the oscillators, the watchdog counter and the clock monitor are outside the block. They appear only as event inputs and as the clock-select output.

Top module: `rst_hub`

## Requirements
- R1: The external pin `ext_rst_n` passes through a two-flop synchronizer. When the pin is low at rising edge k, `sys_rst` is 1 after edge k+2, which is the third edge that sees the pin low.
- R2: When `wdt_ovf`, `lvd_trip` or `clkmon_stop` is 1 at a rising edge, `sys_rst` is 1 after that edge.
- R3: After the last edge that samples an active source, `sys_rst` stays 1 for HOLD_CYC (default 16) more edges and goes to 0 at the edge after those.
- R4: `cpu_run` is 0 whenever `sys_rst` is 1. It goes to 1 exactly STAB_CYC (default 256) cycles after `sys_rst` goes to 0.
- R5: Register address 0 holds the source flags: bit 0 for the watchdog, bit 1 for the clock monitor and bit 2 for low voltage. Each flag is set by its own source, survives the reset it causes, and reads as 0 in the other bits. A read (`bus_sel`=1, `bus_wr`=0) updates `bus_rdata` at that edge.
- R6: A write to address 0 clears each flag whose data bit is 0 and leaves flags whose data bit is 1 unchanged. A source event in the same cycle as a clear sets the flag.
- R7: An external pin reset, meaning the synchronized request is active, clears all flags. It also takes priority over simultaneous source events.
- R8: Address 1 (detector mode) and address 2 (detector level) are read/write and drive `lvd_mode_o`/`lvd_level_o`. Writes are ignored while `sys_rst` is 1. `por`, the pin, the watchdog and the clock monitor clear both registers. A low-voltage reset leaves them unchanged.
- R9: A watchdog overflow while `sys_rst` is 0 and `cpu_run` is 0 sets emergency mode after that edge. `emerg_o`, `clk_sel_int` and bit 0 of address 3 all read 1.
- R10: Emergency mode survives watchdog resets. It is cleared only by an external pin reset, a low-voltage trip or `por`.
- R11: `per_acc` with an identifier outside ALLOW_MASK (default: ids 0 to 3 allowed) while in emergency mode gives `illegal_o`=1 for the next cycle. Outside emergency mode `illegal_o` stays 0.
- R12: `por` is a synchronous active-high power-on reset. After it, `sys_rst`=1, `cpu_run`=0, `emerg_o`=0, the flags are 0, both detector registers are 0 and `bus_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| ext_rst_n | input | 1 | External reset pin, asynchronous, active low |
| wdt_ovf | input | 1 | Watchdog overflow event |
| lvd_trip | input | 1 | Low-voltage detector trip |
| clkmon_stop | input | 1 | Clock monitor oscillation-stop event |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| per_acc | input | 1 | Peripheral access strobe |
| per_id | input | ID_W | Peripheral group identifier |
| sys_rst | output | 1 | System reset, active high |
| cpu_run | output | 1 | Reset and stabilization complete |
| clk_sel_int | output | 1 | 1 = internal oscillator selected |
| emerg_o | output | 1 | Emergency mode active |
| illegal_o | output | 1 | Illegal peripheral access in emergency mode |
| lvd_mode_o | output | DW | Detector mode register |
| lvd_level_o | output | DW | Detector level register |

## Verification
Each source is driven alone to show that it sets its own flag and no other. The low-voltage trip is set against the watchdog and clock-monitor events to tell apart the one reset that preserves the detector registers. A watchdog overflow in the running state is compared with one during the stabilization wait, which separates an ordinary reset from entry into emergency mode. A clear write that coincides with a source event checks set-over-clear priority. A pin reset, a low-voltage trip and a repeated watchdog reset are applied in emergency mode to show which exits it and which does not.

// File: rtl/rst_hub_pkg.sv
package rst_hub_pkg;
  typedef enum logic [1:0] {
    RA_FLAGS   = 2'd0,
    RA_LVMODE  = 2'd1,
    RA_LVLEVEL = 2'd2,
    RA_STATUS  = 2'd3
  } reg_addr_e;

  localparam int NFLAGS   = 3;
  localparam int FLAG_WDT = 0;
  localparam int FLAG_CLK = 1;
  localparam int FLAG_LVD = 2;
endpackage

// File: rtl/rst_hub_sync.sv
module rst_hub_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rst_hub_seq.sv
module rst_hub_seq #(
  parameter int HOLD_CYC = 16,
  parameter int STAB_CYC = 256
) (
  input  logic clk,
  input  logic por,
  input  logic ext_req,
  input  logic wdt_ovf,
  input  logic lvd_trip,
  input  logic clkmon_stop,
  output logic sys_rst,
  output logic stab_busy,
  output logic emerg
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam int SW = $clog2(STAB_CYC + 1);

  logic [HW-1:0] hold_q;
  logic          rst_q;
  logic [SW-1:0] stab_q;
  logic          busy_q;
  logic          emg_q;
  logic          src_any;

  assign src_any = ext_req | wdt_ovf | lvd_trip | clkmon_stop;

  // reset stretch
  always_ff @(posedge clk) begin
    if (por || src_any) begin
      rst_q  <= 1'b1;
      hold_q <= HW'(HOLD_CYC);
    end else if (hold_q != '0) begin
      hold_q <= hold_q - 1'b1;
    end else begin
      rst_q <= 1'b0;
    end
  end

  // main oscillator stabilization wait
  always_ff @(posedge clk) begin
    if (por || rst_q) begin
      busy_q <= 1'b1;
      stab_q <= SW'(STAB_CYC - 1);
    end else if (busy_q) begin
      if (stab_q == '0) busy_q <= 1'b0;
      else              stab_q <= stab_q - 1'b1;
    end
  end

  // emergency mode: exit has priority over entry
  always_ff @(posedge clk) begin
    if (por || ext_req || lvd_trip) emg_q <= 1'b0;
    else if (wdt_ovf && !rst_q && busy_q) emg_q <= 1'b1;
  end

  assign sys_rst   = rst_q;
  assign stab_busy = busy_q;
  assign emerg     = emg_q;
endmodule

// File: rtl/rst_hub_regs.sv
module rst_hub_regs
  import rst_hub_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          por,
  input  logic          blk,
  input  logic          ext_req,
  input  logic          wdt_ovf,
  input  logic          lvd_trip,
  input  logic          clkmon_stop,
  input  logic          emerg,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] lvd_mode,
  output logic [DW-1:0] lvd_level
);
  logic [NFLAGS-1:0] flags_q;
  logic [NFLAGS-1:0] set_vec;
  logic [NFLAGS-1:0] clr_vec;
  logic [DW-1:0]     mode_q;
  logic [DW-1:0]     lvl_q;
  logic [DW-1:0]     rdata_q;
  logic              wr_en;
  reg_addr_e         ra;

  assign ra      = reg_addr_e'(bus_addr);
  assign wr_en   = bus_sel & bus_wr & ~blk;

  always_comb begin
    set_vec           = '0;
    set_vec[FLAG_WDT] = wdt_ovf;
    set_vec[FLAG_CLK] = clkmon_stop;
    set_vec[FLAG_LVD] = lvd_trip;
    clr_vec           = (wr_en && ra == RA_FLAGS) ? ~bus_wdata[NFLAGS-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (por || ext_req) flags_q <= '0;
    else                flags_q <= set_vec | (flags_q & ~clr_vec);
  end

  always_ff @(posedge clk) begin
    if (por || ext_req || wdt_ovf || clkmon_stop) begin
      mode_q <= '0;
      lvl_q  <= '0;
    end else if (wr_en) begin
      if (ra == RA_LVMODE)  mode_q <= bus_wdata;
      if (ra == RA_LVLEVEL) lvl_q  <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (por) rdata_q <= '0;
    else if (bus_sel && !bus_wr) begin
      case (ra)
        RA_FLAGS:   rdata_q <= {{(DW-NFLAGS){1'b0}}, flags_q};
        RA_LVMODE:  rdata_q <= mode_q;
        RA_LVLEVEL: rdata_q <= lvl_q;
        default:    rdata_q <= {{(DW-1){1'b0}}, emerg};
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign lvd_mode  = mode_q;
  assign lvd_level = lvl_q;
endmodule

// File: rtl/rst_hub_guard.sv
module rst_hub_guard #(
  parameter int                 ID_W       = 4,
  parameter logic [2**ID_W-1:0] ALLOW_MASK = 16'h000F
) (
  input  logic            clk,
  input  logic            por,
  input  logic            emerg,
  input  logic            per_acc,
  input  logic [ID_W-1:0] per_id,
  output logic            illegal
);
  logic ill_q;

  always_ff @(posedge clk) begin
    if (por) ill_q <= 1'b0;
    else     ill_q <= per_acc & emerg & ~ALLOW_MASK[per_id];
  end

  assign illegal = ill_q;
endmodule

// File: rtl/rst_hub.sv
module rst_hub #(
  parameter int                 DW         = 8,
  parameter int                 HOLD_CYC   = 16,
  parameter int                 STAB_CYC   = 256,
  parameter int                 SYNC_STG   = 2,
  parameter int                 ID_W       = 4,
  parameter logic [2**ID_W-1:0] ALLOW_MASK = 16'h000F
) (
  input  logic            clk,
  input  logic            por,
  input  logic            ext_rst_n,
  input  logic            wdt_ovf,
  input  logic            lvd_trip,
  input  logic            clkmon_stop,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [1:0]      bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic            per_acc,
  input  logic [ID_W-1:0] per_id,
  output logic            sys_rst,
  output logic            cpu_run,
  output logic            clk_sel_int,
  output logic            emerg_o,
  output logic            illegal_o,
  output logic [DW-1:0]   lvd_mode_o,
  output logic [DW-1:0]   lvd_level_o
);
  logic ext_req;
  logic stab_busy;
  logic emerg;

  rst_hub_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk (clk),
    .rst (por),
    .d   (~ext_rst_n),
    .q   (ext_req)
  );

  rst_hub_seq #(.HOLD_CYC(HOLD_CYC), .STAB_CYC(STAB_CYC)) u_seq (
    .clk         (clk),
    .por         (por),
    .ext_req     (ext_req),
    .wdt_ovf     (wdt_ovf),
    .lvd_trip    (lvd_trip),
    .clkmon_stop (clkmon_stop),
    .sys_rst     (sys_rst),
    .stab_busy   (stab_busy),
    .emerg       (emerg)
  );

  rst_hub_regs #(.DW(DW)) u_regs (
    .clk         (clk),
    .por         (por),
    .blk         (sys_rst),
    .ext_req     (ext_req),
    .wdt_ovf     (wdt_ovf),
    .lvd_trip    (lvd_trip),
    .clkmon_stop (clkmon_stop),
    .emerg       (emerg),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .lvd_mode    (lvd_mode_o),
    .lvd_level   (lvd_level_o)
  );

  rst_hub_guard #(.ID_W(ID_W), .ALLOW_MASK(ALLOW_MASK)) u_guard (
    .clk     (clk),
    .por     (por),
    .emerg   (emerg),
    .per_acc (per_acc),
    .per_id  (per_id),
    .illegal (illegal_o)
  );

  assign cpu_run     = ~sys_rst & ~stab_busy;
  assign clk_sel_int = emerg;
  assign emerg_o     = emerg;
endmodule

// File: rtl/rst_hub_chk.sv
module rst_hub_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          por,
  input logic          ext_req,
  input logic          wdt_ovf,
  input logic          lvd_trip,
  input logic          clkmon_stop,
  input logic          sys_rst,
  input logic          cpu_run,
  input logic          emerg_o,
  input logic          illegal_o,
  input logic [DW-1:0] lvd_mode_o,
  input logic [DW-1:0] lvd_level_o
);
  a_r2_src_asserts: assert property (@(posedge clk) disable iff (por)
    (wdt_ovf || lvd_trip || clkmon_stop) |=> sys_rst);

  a_r3_release_quiet: assert property (@(posedge clk) disable iff (por)
    $fell(sys_rst) |-> !$past(wdt_ovf || lvd_trip || clkmon_stop || ext_req));

  a_r4_no_run_in_reset: assert property (@(posedge clk) disable iff (por)
    sys_rst |-> !cpu_run);

  a_r8_lvd_keeps_regs: assert property (@(posedge clk) disable iff (por)
    (lvd_trip && sys_rst && !ext_req && !wdt_ovf && !clkmon_stop)
      |=> ($stable(lvd_mode_o) && $stable(lvd_level_o)));

  a_r8_other_clears_regs: assert property (@(posedge clk) disable iff (por)
    (wdt_ovf || clkmon_stop) |=> (lvd_mode_o == '0 && lvd_level_o == '0));

  a_r9_emerg_entry: assert property (@(posedge clk) disable iff (por)
    (wdt_ovf && !sys_rst && !cpu_run && !ext_req && !lvd_trip) |=> emerg_o);

  a_r10_lvd_exit: assert property (@(posedge clk) disable iff (por)
    lvd_trip |=> !emerg_o);

  a_r11_illegal_needs_emerg: assert property (@(posedge clk) disable iff (por)
    illegal_o |-> $past(emerg_o));
endmodule

bind rst_hub rst_hub_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .por         (por),
  .ext_req     (ext_req),
  .wdt_ovf     (wdt_ovf),
  .lvd_trip    (lvd_trip),
  .clkmon_stop (clkmon_stop),
  .sys_rst     (sys_rst),
  .cpu_run     (cpu_run),
  .emerg_o     (emerg_o),
  .illegal_o   (illegal_o),
  .lvd_mode_o  (lvd_mode_o),
  .lvd_level_o (lvd_level_o)
);

// File: tb/sim_rst_hub.sv
module sim_rst_hub;
  localparam int CLK_PERIOD = 10;
  localparam int DW   = 8;
  localparam int HOLD = 16;
  localparam int STAB = 256;
  localparam int IDW  = 4;

  logic clk = 1'b0;
  logic por = 1'b1;
  logic ext_rst_n = 1'b1;
  logic wdt_ovf = 0, lvd_trip = 0, clkmon_stop = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic per_acc = 0;
  logic [IDW-1:0] per_id = '0;
  logic sys_rst, cpu_run, clk_sel_int, emerg_o, illegal_o;
  logic [DW-1:0] lvd_mode_o, lvd_level_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit model_on = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_hub u0 (
    .clk(clk), .por(por), .ext_rst_n(ext_rst_n), .wdt_ovf(wdt_ovf),
    .lvd_trip(lvd_trip), .clkmon_stop(clkmon_stop), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .per_acc(per_acc), .per_id(per_id),
    .sys_rst(sys_rst), .cpu_run(cpu_run), .clk_sel_int(clk_sel_int),
    .emerg_o(emerg_o), .illegal_o(illegal_o), .lvd_mode_o(lvd_mode_o),
    .lvd_level_o(lvd_level_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  int m_p1, m_p2, m_rst, m_hold, m_busy, m_stc, m_emg, m_flags, m_mode, m_lvl, m_rd, m_ill;

  always @(posedge clk) begin : model
    int src, wr, clrm, n_rst, n_hold, n_busy, n_stc, n_emg, n_flags, n_mode, n_lvl, n_rd;
    cyc++;
    if (por) begin
      m_p1 = 0; m_p2 = 0; m_rst = 1; m_hold = HOLD; m_busy = 1; m_stc = STAB - 1;
      m_emg = 0; m_flags = 0; m_mode = 0; m_lvl = 0; m_rd = 0; m_ill = 0;
      model_on = 1;
    end else begin
      src = m_p2 | wdt_ovf | lvd_trip | clkmon_stop;
      n_rst = m_rst; n_hold = m_hold;
      if (src != 0) begin n_rst = 1; n_hold = HOLD; end
      else if (m_hold != 0) n_hold = m_hold - 1;
      else n_rst = 0;
      n_busy = m_busy; n_stc = m_stc;
      if (m_rst != 0) begin n_busy = 1; n_stc = STAB - 1; end
      else if (m_busy != 0) begin
        if (m_stc == 0) n_busy = 0; else n_stc = m_stc - 1;
      end
      n_emg = m_emg;
      if (m_p2 != 0 || lvd_trip) n_emg = 0;
      else if (wdt_ovf && m_rst == 0 && m_busy != 0) n_emg = 1;
      wr = (bus_sel && bus_wr && m_rst == 0) ? 1 : 0;
      clrm = (wr != 0 && bus_addr == 2'd0) ? (~int'(bus_wdata) & 7) : 0;
      if (m_p2 != 0) n_flags = 0;
      else n_flags = (m_flags & ~clrm) | (wdt_ovf ? 1 : 0) | (clkmon_stop ? 2 : 0) | (lvd_trip ? 4 : 0);
      n_mode = m_mode; n_lvl = m_lvl;
      if (m_p2 != 0 || wdt_ovf || clkmon_stop) begin n_mode = 0; n_lvl = 0; end
      else if (wr != 0) begin
        if (bus_addr == 2'd1) n_mode = int'(bus_wdata);
        if (bus_addr == 2'd2) n_lvl  = int'(bus_wdata);
      end
      n_rd = m_rd;
      if (bus_sel && !bus_wr) begin
        case (bus_addr)
          2'd0: n_rd = m_flags;
          2'd1: n_rd = m_mode;
          2'd2: n_rd = m_lvl;
          default: n_rd = m_emg;
        endcase
      end
      m_ill = (per_acc && m_emg != 0 && per_id > 3) ? 1 : 0;
      m_p2 = m_p1; m_p1 = ext_rst_n ? 0 : 1;
      m_rst = n_rst; m_hold = n_hold; m_busy = n_busy; m_stc = n_stc; m_emg = n_emg;
      m_flags = n_flags; m_mode = n_mode; m_lvl = n_lvl; m_rd = n_rd;
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      chk("R3", "sys_rst", int'(sys_rst), m_rst);
      chk("R4", "cpu_run", int'(cpu_run), (m_rst == 0 && m_busy == 0) ? 1 : 0);
      chk("R9", "clk_sel_int", int'(clk_sel_int), m_emg);
      chk("R10", "emerg_o", int'(emerg_o), m_emg);
      chk("R8", "lvd_mode_o", int'(lvd_mode_o), m_mode);
      chk("R8", "lvd_level_o", int'(lvd_level_o), m_lvl);
      chk("R5", "bus_rdata", int'(bus_rdata), m_rd);
      chk("R11", "illegal_o", int'(illegal_o), m_ill);
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_wdt();  @(negedge clk); wdt_ovf = 1;     @(negedge clk); wdt_ovf = 0;     endtask
  task automatic pulse_lvd();  @(negedge clk); lvd_trip = 1;    @(negedge clk); lvd_trip = 0;    endtask
  task automatic pulse_clk();  @(negedge clk); clkmon_stop = 1; @(negedge clk); clkmon_stop = 0; endtask

  task automatic wait_run();
    for (int i = 0; i < 3000 && !cpu_run; i++) @(negedge clk);
  endtask

  task automatic wait_rst_low();
    for (int i = 0; i < 3000 && sys_rst; i++) @(negedge clk);
  endtask

  task automatic bus_write(input int a, input int d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = 2'(a); bus_wdata = DW'(d);
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input int a, output int d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = 2'(a);
    @(negedge clk); bus_sel = 0; d = int'(bus_rdata);
  endtask

  task automatic access(input int id, output int ill);
    @(negedge clk); per_acc = 1; per_id = IDW'(id);
    @(negedge clk); per_acc = 0; ill = int'(illegal_o);
  endtask

  initial begin
    int v;
    ticks(3);
    chk("R12", "sys_rst in por", int'(sys_rst), 1);
    chk("R12", "cpu_run in por", int'(cpu_run), 0);
    chk("R12", "emerg in por", int'(emerg_o), 0);
    chk("R12", "lvd_mode in por", int'(lvd_mode_o), 0);
    por = 0;
    wait_run();
    bus_read(0, v);  chk("R7", "flags after por", v, 0);
    bus_write(1, 8'hA5); bus_write(2, 8'h3C);
    bus_read(1, v);  chk("R8", "mode readback", v, 8'hA5);
    bus_read(2, v);  chk("R8", "level readback", v, 8'h3C);

    // watchdog reset in run: timing of hold and stabilization
    @(negedge clk); wdt_ovf = 1;
    @(negedge clk); wdt_ovf = 0;
    chk("R2", "sys_rst after wdt", int'(sys_rst), 1);
    ticks(HOLD);
    chk("R3", "sys_rst at end of hold", int'(sys_rst), 1);
    ticks(1);
    chk("R3", "sys_rst released", int'(sys_rst), 0);
    ticks(STAB - 1);
    chk("R4", "cpu_run before stab end", int'(cpu_run), 0);
    ticks(1);
    chk("R4", "cpu_run after stab", int'(cpu_run), 1);
    chk("R9", "no emerg for wdt in run", int'(emerg_o), 0);
    bus_read(0, v);  chk("R5", "wdt flag", v, 1);
    chk("R8", "mode cleared by wdt", int'(lvd_mode_o), 0);

    // low-voltage reset keeps detector regs
    bus_write(1, 8'h5A); bus_write(2, 8'h11);
    pulse_lvd();
    chk("R2", "sys_rst after lvd", int'(sys_rst), 1);
    wait_run();
    bus_read(0, v);  chk("R5", "wdt+lvd flags", v, 5);
    chk("R8", "mode kept over lvd reset", int'(lvd_mode_o), 8'h5A);
    chk("R8", "level kept over lvd reset", int'(lvd_level_o), 8'h11);

    pulse_clk();
    wait_run();
    bus_read(0, v);  chk("R5", "all flags", v, 7);
    chk("R8", "mode cleared by clkmon", int'(lvd_mode_o), 0);

    bus_write(0, 3);
    bus_read(0, v);  chk("R6", "clear lvd flag only", v, 3);

    // clear write coinciding with a watchdog event: set wins
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = 2'd0; bus_wdata = '0; wdt_ovf = 1;
    @(negedge clk); bus_sel = 0; bus_wr = 0; wdt_ovf = 0;
    wait_run();
    bus_read(0, v);  chk("R6", "set wins over clear", v, 1);

    // write during reset is ignored
    bus_write(1, 8'h77);
    pulse_lvd();
    bus_write(1, 8'hFF);
    wait_run();
    chk("R8", "write in reset ignored", int'(lvd_mode_o), 8'h77);

    // emergency entry
    pulse_wdt();
    wait_rst_low();
    pulse_wdt();
    chk("R9", "emerg after wdt in stab", int'(emerg_o), 1);
    chk("R9", "internal clock selected", int'(clk_sel_int), 1);
    wait_run();
    chk("R10", "emerg kept over wdt reset", int'(emerg_o), 1);
    bus_read(3, v);  chk("R9", "status bit", v, 1);
    access(2, v);    chk("R11", "allowed id in emerg", v, 0);
    access(9, v);    chk("R11", "illegal id in emerg", v, 1);
    ticks(1);        chk("R11", "illegal is one cycle", int'(illegal_o), 0);
    pulse_wdt();
    wait_run();
    chk("R10", "emerg kept after second wdt", int'(emerg_o), 1);
    pulse_lvd();
    chk("R10", "lvd exits emerg", int'(emerg_o), 0);
    wait_run();

    // re-enter, then pin reset
    pulse_wdt();
    wait_rst_low();
    pulse_wdt();
    wait_run();
    chk("R10", "emerg re-entered", int'(emerg_o), 1);
    @(negedge clk); ext_rst_n = 0;
    ticks(2);
    chk("R1", "sys_rst not yet (sync)", int'(sys_rst), 0);
    ticks(1);
    chk("R1", "sys_rst after sync", int'(sys_rst), 1);
    ticks(4);
    ext_rst_n = 1;
    wait_run();
    chk("R10", "pin exits emerg", int'(emerg_o), 0);
    bus_read(0, v);  chk("R7", "pin clears flags", v, 0);
    access(9, v);    chk("R11", "no illegal outside emerg", v, 0);

    ticks(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule